// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital half of a successive-approximation analog-to-digital converter. An external DAC is driven from the block's trial code, and an external comparator reports back whether that DAC level is still at or below the analog input. A single start pulse launches a conversion. The block then decides one bit per clock, beginning at the most significant bit. For each bit it raises that bit on top of the bits already settled, reads the comparator, and either keeps or drops the bit.

After exactly `N_BITS` clocks the settled code is copied to the result output and the end-of-conversion flag is raised. Both stay put until the next start. A start that arrives while a conversion is running abandons that conversion and begins a fresh one. The converter width is a parameter, and every internal width is derived from it.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `eoc` = 0, `result` = 0 and `dac_code` = 0.
- R2: A `start` sampled high clears the trial register and drops `eoc` for the next cycle; in that cycle `dac_code` equals only the MSB set (e.g. 8'h80 for 8 bits).
- R3: Bits are tried MSB first, one per clock: during the trial of bit k, `dac_code` holds the bits above k at their decided values, bit k at 1 and all bits below k at 0.
- R4: At the end of a trial, bit k is kept at 1 when `comp_hi` is 1 (DAC level not above the input) and cleared to 0 when `comp_hi` is 0.
- R5: `eoc` rises exactly `N_BITS` clock edges after the edge that sampled `start`.
- R6: With an ideal comparator (`comp_hi` = DAC code ≤ input code), `result` equals the input code for every input in range, including 0 and full scale.
- R7: Once `eoc` is high, `result`, `eoc` and `dac_code` hold their values, and `comp_hi` has no effect until the next `start`.
- R8: A `start` sampled during a conversion restarts it from the MSB. The final result reflects only the input seen after the restart, and it arrives `N_BITS` edges after the restart.
- R9: A `start` after completion drops `eoc` on the next cycle, while `result` keeps the previous conversion's value until the new conversion completes.
- R10: The block works for any `N_BITS` ≥ 1, including a single-bit converter that completes one edge after `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) a conversion |
| comp_hi | input | 1 | Comparator: 1 while DAC level is not above the input |
| dac_code | output | N_BITS | Trial code for the external DAC |
| result | output | N_BITS | Last completed conversion code |
| eoc | output | 1 | End of conversion, high until next start |

## Verification
The bench builds two copies of the block. The first uses the default eight-bit width. It runs a table of input codes that covers both rails, the mid-scale boundary and alternating bit patterns, and it follows the trial code step by step. The second uses a one-bit width. There the first trial is also the last one, so the start, decision and completion paths all collapse into a single edge, a case the wide build cannot reach.

// File: rtl/sar_pkg.sv
package sar_pkg;

   typedef enum logic [1:0] {
      SAR_IDLE = 2'd0,
      SAR_RUN  = 2'd1,
      SAR_DONE = 2'd2
   } sar_state_e;

   function automatic int unsigned sar_cnt_width(input int unsigned nbits);
      return (nbits < 2) ? 1 : $clog2(nbits + 1);
   endfunction

endpackage

// File: rtl/sar_bit_seq.sv
module sar_bit_seq
   import sar_pkg::*;
#(
   parameter int unsigned N_BITS = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   output logic [N_BITS-1:0] ptr,
   output logic              busy,
   output logic              last
);

   localparam logic [N_BITS-1:0] MSB_ONLY = {1'b1, {(N_BITS-1){1'b0}}} >> 0;

   sar_state_e        state_q;
   logic [N_BITS-1:0] ptr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SAR_IDLE;
         ptr_q   <= '0;
      end else if (start) begin
         state_q <= SAR_RUN;
         ptr_q   <= MSB_ONLY;
      end else if (state_q == SAR_RUN) begin
         if (ptr_q[0]) begin
            state_q <= SAR_DONE;
            ptr_q   <= '0;
         end else begin
            ptr_q   <= ptr_q >> 1;
         end
      end
   end

   assign busy = (state_q == SAR_RUN);
   assign ptr  = ptr_q;
   assign last = busy && ptr_q[0];

   // R3
   ptr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ptr_q));

   // R3
   ptr_walk_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !start && !ptr_q[0]) |=> (busy && ptr_q == ($past(ptr_q) >> 1)));

   // R8
   restart_msb_chk: assert property (@(posedge clk) disable iff (rst)
      start |=> (busy && ptr_q == MSB_ONLY));

   // R3
   run_ptr_live_chk: assert property (@(posedge clk) disable iff (rst)
      busy |-> (ptr_q != '0));

endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
   parameter int unsigned N_BITS = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clear,
   input  logic              step,
   input  logic [N_BITS-1:0] ptr,
   input  logic              comp_hi,
   output logic [N_BITS-1:0] code_q,
   output logic [N_BITS-1:0] code_next
);

   for (genvar b = 0; b < N_BITS; b++) begin : g_bit
      always_comb begin
         if (clear)
            code_next[b] = 1'b0;
         else if (step && ptr[b])
            code_next[b] = comp_hi;
         else
            code_next[b] = code_q[b];
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         code_q <= '0;
      else
         code_q <= code_next;
   end

   // R4
   keep_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (step && !clear) |=> (((code_q & $past(ptr)) != '0) == $past(comp_hi)));

   // R2
   clear_chk: assert property (@(posedge clk) disable iff (rst)
      clear |=> (code_q == '0));

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
   import sar_pkg::*;
#(
   parameter int unsigned N_BITS = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              comp_hi,
   output logic [N_BITS-1:0] dac_code,
   output logic [N_BITS-1:0] result,
   output logic              eoc
);

   localparam int unsigned CW = sar_cnt_width(N_BITS);

   if (N_BITS < 1) begin : g_bad_width
      $error("sar_adc_ctrl: N_BITS must be at least 1");
   end

   logic [N_BITS-1:0] ptr;
   logic              busy;
   logic              last;
   logic [N_BITS-1:0] code_q;
   logic [N_BITS-1:0] code_next;
   logic [N_BITS-1:0] result_q;
   logic              eoc_q;

   sar_bit_seq #(.N_BITS(N_BITS)) seq_i (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .ptr   (ptr),
      .busy  (busy),
      .last  (last)
   );

   sar_code_reg #(.N_BITS(N_BITS)) code_i (
      .clk       (clk),
      .rst       (rst),
      .clear     (start),
      .step      (busy),
      .ptr       (ptr),
      .comp_hi   (comp_hi),
      .code_q    (code_q),
      .code_next (code_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         eoc_q    <= 1'b0;
         result_q <= '0;
      end else if (start) begin
         eoc_q    <= 1'b0;
      end else if (last) begin
         eoc_q    <= 1'b1;
         result_q <= code_next;
      end
   end

   assign dac_code = code_q | ptr;
   assign result   = result_q;
   assign eoc      = eoc_q;

   logic [CW-1:0] run_cnt;
   always_ff @(posedge clk) begin
      if (rst || start)
         run_cnt <= '0;
      else if (busy)
         run_cnt <= run_cnt + 1'b1;
   end

   // R5
   conv_len_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(eoc_q) |-> (run_cnt == CW'(N_BITS)));

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      (eoc_q && !start) |=> (eoc_q && $stable(result_q) && $stable(dac_code)));

   // R2
   start_drop_chk: assert property (@(posedge clk) disable iff (rst)
      start |=> !eoc_q);

   // R9
   keep_old_chk: assert property (@(posedge clk) disable iff (rst)
      (start && !last) |=> $stable(result_q));

   // R3
   trial_shape_chk: assert property (@(posedge clk) disable iff (rst)
      busy |-> (!eoc_q && (dac_code & ptr) == ptr && (dac_code & (ptr - 1'b1)) == '0));

endmodule

// File: tb/sar_adc_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_adc_ctrl_tb_top;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   logic       start8 = 1'b0;
   logic [7:0] vin8   = '0;
   logic [7:0] dac8, res8;
   logic       eoc8, comp8;
   assign comp8 = (dac8 <= vin8);

   logic       start1 = 1'b0;
   logic [0:0] vin1   = '0;
   logic [0:0] dac1, res1;
   logic       eoc1, comp1;
   assign comp1 = (dac1 <= vin1);

   sar_adc_ctrl #(.N_BITS(8)) dut_i (
      .clk(clk), .rst(rst), .start(start8), .comp_hi(comp8),
      .dac_code(dac8), .result(res8), .eoc(eoc8));

   sar_adc_ctrl #(.N_BITS(1)) dut1_i (
      .clk(clk), .rst(rst), .start(start1), .comp_hi(comp1),
      .dac_code(dac1), .result(res1), .eoc(eoc1));

   int n_run  = 0;
   int n_fail = 0;
   bit finished = 0;

   localparam int NV = 8;
   localparam logic [7:0] VIN_TAB [NV] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'h55, 8'hAA, 8'hC8};
   localparam logic [7:0] EXP_TAB [NV] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'h55, 8'hAA, 8'hC8};

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Called at a falling edge; leaves at the falling edge after eoc rises.
   task automatic convert8(input logic [7:0] v, output int cycles);
      logic [7:0] expd;
      vin8 = v;
      start8 = 1'b1;
      @(negedge clk);
      start8 = 1'b0;
      chk(eoc8 == 1'b0, "R2 eoc low after start", eoc8, 0);
      cycles = 0;
      while (!eoc8 && cycles < 20) begin
         if (cycles < 8) begin
            expd = (v & ~((8'd1 << (8 - cycles)) - 8'd1)) | (8'd1 << (7 - cycles));
            if (cycles == 0) expd = 8'h80;
            chk(dac8 == expd, "R3/R4 trial code", dac8, expd);
         end
         @(negedge clk);
         cycles++;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int cyc;
      logic [7:0] held;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(eoc8 == 0 && res8 == 0 && dac8 == 0, "R1 reset outputs", {eoc8, res8, dac8}, 0);
      rst = 1'b0;
      @(negedge clk);

      // R6 table of input codes
      for (int i = 0; i < NV; i++) begin
         convert8(VIN_TAB[i], cyc);
         chk(cyc == 8, "R5 conversion length", cyc, 8);
         chk(res8 == EXP_TAB[i], "R6 result", res8, EXP_TAB[i]);
      end

      // R7 hold and comparator ignored after completion
      held = res8;
      for (int k = 0; k < 5; k++) begin
         vin8 = 8'(k * 61);
         @(negedge clk);
         chk(eoc8 && res8 == held && dac8 == held, "R7 hold while idle", res8, held);
      end

      // R9 start after completion
      vin8 = 8'h3C;
      start8 = 1'b1;
      @(negedge clk);
      start8 = 1'b0;
      chk(eoc8 == 0, "R9 eoc drops", eoc8, 0);
      chk(res8 == held, "R9 old result kept", res8, held);
      repeat (3) @(negedge clk);
      chk(res8 == held && !eoc8, "R9 old result mid conversion", res8, held);

      // R8 restart mid conversion
      convert8(8'hE7, cyc);
      chk(cyc == 8, "R8 restart length", cyc, 8);
      chk(res8 == 8'hE7, "R8 restart result", res8, 8'hE7);

      // R1 reset during a conversion
      vin8 = 8'h44;
      start8 = 1'b1;
      @(negedge clk);
      start8 = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(eoc8 == 0 && res8 == 0 && dac8 == 0, "R1 reset mid conversion", {eoc8, res8, dac8}, 0);
      rst = 1'b0;
      repeat (10) @(negedge clk);
      chk(eoc8 == 0 && dac8 == 0, "R1 idle after reset", {eoc8, dac8}, 0);

      // R10 single-bit converter
      for (int b = 0; b < 2; b++) begin
         vin1 = 1'(b);
         start1 = 1'b1;
         @(negedge clk);
         start1 = 1'b0;
         chk(dac1 == 1'b1 && !eoc1, "R10 single-bit trial", dac1, 1);
         @(negedge clk);
         chk(eoc1 == 1'b1, "R10 single-bit eoc", eoc1, 1);
         chk(res1 == 1'(b), "R10 single-bit result", res1, b);
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule